// File: doc/BRIEF.md
# UART interrupt identification and status core

This block holds the status and interrupt side of a 16550-style UART register file. The receiver, the transmitter and the modem pins feed it events. It keeps sticky error flags, modem change flags, an interrupt enable mask and a pending transmit-empty condition. From these it builds a prioritised 3-bit identification code and a single interrupt line. The serial shifters, the FIFO storage and the baud generator sit outside it. The block drives their control through the line control, modem control and divisor outputs, and through strobes for data-port and FIFO-control accesses.

A byte-wide host port with chip select, read and write strobes reaches eight offsets. Read data is combinational in the cycle of the read strobe. The side effects of a read take place on the clock edge that ends the access. These side effects are clearing the error flags, clearing the modem change flags, clearing the transmit-empty condition and popping receive data. Bit 7 of the line control register makes offsets 0 and 1 reach the two divisor bytes.

Top module: `uart_irq_status_core`

## Requirements
- R1: After reset, the identification register reads 0x01, line control and modem control read 0x00, line status bits 1 to 4 read 0 and `irq_o` is low. With all modem inputs low, modem status reads 0xF0.
- R2: The offsets are 0 data, 1 enable, 2 identification (read) or FIFO control (write), 3 line control, 4 modem control, 5 line status, 6 modem status, and 7 reads 0. With line control bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes, and `divisor_o` = {high, low}. Such writes leave the enable register unchanged.
- R3: The enable register holds 4 bits that read back in bits 3:0, with bits 7:4 reading 0. Bit 0 enables receive data, bit 1 transmit empty, bit 2 line errors and bit 3 modem changes. `irq_o` is the OR of the enabled pending sources, and it drops in the cycle after the last of them is cleared.
- R4: Line status bit 0 follows `rx_avail_i` and bit 5 follows `thr_empty_i`. Bit 6 follows `tx_empty_i` and bit 7 is 0. Bits 1, 2, 3 and 4 are sticky flags, set by one-cycle pulses on `ovr_err_i`, `par_err_i`, `frm_err_i` and `brk_i` respectively.
- R5: A line status read clears bits 1 to 4 at the end of the access. An error pulse in the same cycle as the read leaves its flag set.
- R6: Modem status bits 0 to 3 are change flags for CTS, DSR, RI and DCD. Each flag sets when its input differs from the level sampled on the previous edge. Bits 4 to 7 hold the complement of those sampled levels, in the same order.
- R7: A modem status read clears the four change flags. A change in the same cycle as the read stays flagged.
- R8: Identification bits 7:3 are 0. Bits 2:0 are 0x1 when nothing enabled is pending. Otherwise they give the highest enabled pending source: 0x6 line errors, then 0x4 receive data, then 0x2 transmit empty, then 0x0 modem change.
- R9: The transmit-empty condition sets on a rising edge of `thr_empty_i`. It also sets when an enable write raises bit 1 from 0 to 1 while `thr_empty_i` is high. It clears on an identification read that returned 0x02, or on a data write at offset 0 with bit 7 of line control clear.
- R10: With line control bit 7 clear, a read of offset 0 returns `rx_data_i` and pulses `rx_rd_o`, and a write of offset 0 pulses `tx_we_o`. A write of offset 2 pulses `fcr_we_o`. With bit 7 set, offset 0 accesses raise neither data strobe. Read and write are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host chip select |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational |
| rx_data_i | input | 8 | Byte at the head of the receive path |
| rx_avail_i | input | 1 | Receive data available (level) |
| ovr_err_i | input | 1 | Overrun pulse |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| brk_i | input | 1 | Break detected pulse |
| thr_empty_i | input | 1 | Transmit holding empty (level) |
| tx_empty_i | input | 1 | Transmitter fully empty (level) |
| cts_i | input | 1 | CTS level, synchronised |
| dsr_i | input | 1 | DSR level, synchronised |
| ri_i | input | 1 | RI level, synchronised |
| dcd_i | input | 1 | DCD level, synchronised |
| tx_we_o | output | 1 | Transmit data write strobe (data is wdata_i) |
| rx_rd_o | output | 1 | Receive data pop strobe |
| fcr_we_o | output | 1 | FIFO control write strobe (data is wdata_i) |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| divisor_o | output | 16 | Baud divisor |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the error inputs are single-cycle pulses, that the modem inputs are already synchronous to `clk_i`, and that no access asserts read and write together. The bench keeps to this. It drives every input on the falling edge, and it raises each error strobe for exactly one cycle. Each host access is a one-cycle strobe followed by an idle cycle. The sweep crosses all sixteen enable masks with all sixteen combinations of pending sources. It checks identification, interrupt, line status and modem status against values the bench computes from the priority order.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned AW       = 3;
  localparam int unsigned NUM_ERR  = 4;
  localparam int unsigned NUM_MDM  = 4;
  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned DLAB_BIT = 7;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_IER  = 3'd1;
  localparam logic [AW-1:0] OFS_IIR  = 3'd2;
  localparam logic [AW-1:0] OFS_LCR  = 3'd3;
  localparam logic [AW-1:0] OFS_MCR  = 3'd4;
  localparam logic [AW-1:0] OFS_LSR  = 3'd5;
  localparam logic [AW-1:0] OFS_MSR  = 3'd6;

  // source index = enable bit position
  localparam int unsigned SRC_RX = 0;
  localparam int unsigned SRC_TX = 1;
  localparam int unsigned SRC_LS = 2;
  localparam int unsigned SRC_MS = 3;

  typedef enum logic [2:0] {
    ID_MS   = 3'b000,
    ID_NONE = 3'b001,
    ID_TX   = 3'b010,
    ID_RX   = 3'b100,
    ID_LS   = 3'b110
  } iir_id_e;
endpackage

// File: rtl/uart_host_regs.sv
`timescale 1ns/1ps
module uart_host_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned EN_W   = NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] lcr_o,
  output logic [DATA_W-1:0] mcr_o,
  output logic [EN_W-1:0]   ier_o,
  output logic [DATA_W-1:0] dll_o,
  output logic [DATA_W-1:0] dlm_o,
  output logic              tx_we_o,
  output logic              rx_rd_o,
  output logic              fcr_we_o,
  output logic              iir_rd_o,
  output logic              lsr_rd_o,
  output logic              msr_rd_o,
  output logic              tx_arm_o
);
  logic wr_en, rd_en, dlab;

  assign wr_en = cs_i & wr_i;
  assign rd_en = cs_i & rd_i;
  assign dlab  = lcr_o[DLAB_BIT];

  assign tx_we_o  = wr_en & (addr_i == OFS_DATA) & ~dlab;
  assign rx_rd_o  = rd_en & (addr_i == OFS_DATA) & ~dlab;
  assign fcr_we_o = wr_en & (addr_i == OFS_IIR);
  assign iir_rd_o = rd_en & (addr_i == OFS_IIR);
  assign lsr_rd_o = rd_en & (addr_i == OFS_LSR);
  assign msr_rd_o = rd_en & (addr_i == OFS_MSR);
  // enable of transmit-empty going 0 -> 1
  assign tx_arm_o = wr_en & (addr_i == OFS_IER) & ~dlab
                  & wdata_i[SRC_TX] & ~ier_o[SRC_TX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_o <= '0;
      mcr_o <= '0;
      ier_o <= '0;
      dll_o <= '0;
      dlm_o <= '0;
    end else if (wr_en) begin
      case (addr_i)
        OFS_DATA: if (dlab) dll_o <= wdata_i;
        OFS_IER: begin
          if (dlab) dlm_o <= wdata_i;
          else      ier_o <= wdata_i[EN_W-1:0];
        end
        OFS_LCR: lcr_o <= wdata_i;
        OFS_MCR: mcr_o <= wdata_i;
        default: ;
      endcase
    end
  end

  assert_no_rd_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |-> !(rd_i && wr_i));

  assert_dlab_ier_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == OFS_IER && dlab) |=> $stable(ier_o));
endmodule

// File: rtl/uart_line_status.sv
`timescale 1ns/1ps
module uart_line_status
  import uart_irq_pkg::*;
#(
  parameter int unsigned ERR_N  = NUM_ERR,
  parameter int unsigned DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ERR_N-1:0]  evt_i,
  input  logic              clr_i,
  input  logic              rx_avail_i,
  input  logic              thr_empty_i,
  input  logic              tx_empty_i,
  output logic [DATA_W-1:0] lsr_o,
  output logic              err_any_o
);
  localparam int unsigned PAD_W = DATA_W - ERR_N - 3;

  logic [ERR_N-1:0] flag_q;

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= evt_i[i] | (flag_q[i] & ~clr_i);
    end

    assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flag_q[i]);
  end

  assign err_any_o = |flag_q;
  assign lsr_o     = {{PAD_W{1'b0}}, tx_empty_i, thr_empty_i, flag_q, rx_avail_i};

  assert_lsr_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == '0) |=> (lsr_o[ERR_N:1] == '0));
endmodule

// File: rtl/uart_modem_status.sv
`timescale 1ns/1ps
module uart_modem_status
  import uart_irq_pkg::*;
#(
  parameter int unsigned LINE_N = NUM_MDM
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LINE_N-1:0]   line_i,
  input  logic                clr_i,
  output logic [2*LINE_N-1:0] msr_o,
  output logic                chg_any_o
);
  logic [LINE_N-1:0] lvl_q, chg_q;

  for (genvar i = 0; i < LINE_N; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q[i] <= 1'b0;
        chg_q[i] <= 1'b0;
      end else begin
        lvl_q[i] <= line_i[i];
        chg_q[i] <= (line_i[i] ^ lvl_q[i]) | (chg_q[i] & ~clr_i);
      end
    end

    assert_chg_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_i[i] != lvl_q[i]) |=> (msr_o[i] && msr_o[LINE_N+i] == !$past(line_i[i])));
  end

  assign msr_o     = {~lvl_q, chg_q};
  assign chg_any_o = |chg_q;

  assert_msr_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && line_i == lvl_q) |=> !chg_any_o);
endmodule

// File: rtl/uart_irq_encoder.sv
`timescale 1ns/1ps
module uart_irq_encoder
  import uart_irq_pkg::*;
#(
  parameter int unsigned SRC_N  = NUM_SRC,
  parameter int unsigned DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  ier_i,
  input  logic              ls_any_i,
  input  logic              rx_avail_i,
  input  logic              thr_empty_i,
  input  logic              ms_any_i,
  input  logic              tx_arm_i,
  input  logic              tx_we_i,
  input  logic              iir_rd_i,
  output logic [DATA_W-1:0] iir_o,
  output logic              irq_o
);
  logic             thr_lvl_q, tx_pend_q, tx_set, tx_clr;
  logic [SRC_N-1:0] raw, src, grant;
  iir_id_e          id;

  assign tx_set = (thr_empty_i & ~thr_lvl_q) | (tx_arm_i & thr_empty_i);
  assign tx_clr = tx_we_i | (iir_rd_i & (id == ID_TX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_lvl_q <= 1'b0;
      tx_pend_q <= 1'b0;
    end else begin
      thr_lvl_q <= thr_empty_i;
      tx_pend_q <= tx_set | (tx_pend_q & ~tx_clr);
    end
  end

  always_comb begin
    raw         = '0;
    raw[SRC_RX] = rx_avail_i;
    raw[SRC_TX] = tx_pend_q;
    raw[SRC_LS] = ls_any_i;
    raw[SRC_MS] = ms_any_i;
  end

  for (genvar i = 0; i < SRC_N; i++) begin : g_mask
    assign src[i] = raw[i] & ier_i[i];
  end

  always_comb begin
    grant = '0;
    id    = ID_NONE;
    if (src[SRC_LS]) begin
      grant[SRC_LS] = 1'b1;
      id            = ID_LS;
    end else if (src[SRC_RX]) begin
      grant[SRC_RX] = 1'b1;
      id            = ID_RX;
    end else if (src[SRC_TX]) begin
      grant[SRC_TX] = 1'b1;
      id            = ID_TX;
    end else if (src[SRC_MS]) begin
      grant[SRC_MS] = 1'b1;
      id            = ID_MS;
    end
  end

  assign iir_o = {{(DATA_W-3){1'b0}}, id};
  assign irq_o = |src;

  assert_grant_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  assert_irq_matches_id_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iir_o[0]);

  assert_ls_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src[SRC_LS] |-> (iir_o[2:0] == 3'b110));

  assert_tx_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && iir_o[2:0] == 3'b010 && !tx_set) |=> !tx_pend_q);
endmodule

// File: rtl/uart_irq_status_core.sv
`timescale 1ns/1ps
module uart_irq_status_core
  import uart_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_avail_i,
  input  logic        ovr_err_i,
  input  logic        par_err_i,
  input  logic        frm_err_i,
  input  logic        brk_i,
  input  logic        thr_empty_i,
  input  logic        tx_empty_i,
  input  logic        cts_i,
  input  logic        dsr_i,
  input  logic        ri_i,
  input  logic        dcd_i,
  output logic        tx_we_o,
  output logic        rx_rd_o,
  output logic        fcr_we_o,
  output logic [7:0]  lcr_o,
  output logic [7:0]  mcr_o,
  output logic [15:0] divisor_o,
  output logic        irq_o
);
  localparam int unsigned EN_PAD = DW - NUM_SRC;

  logic [NUM_SRC-1:0]   ier;
  logic [DW-1:0]        dll, dlm, lsr, iir;
  logic [2*NUM_MDM-1:0] msr;
  logic                 iir_rd, lsr_rd, msr_rd, tx_arm, err_any, chg_any;

  uart_host_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .lcr_o    (lcr_o),
    .mcr_o    (mcr_o),
    .ier_o    (ier),
    .dll_o    (dll),
    .dlm_o    (dlm),
    .tx_we_o  (tx_we_o),
    .rx_rd_o  (rx_rd_o),
    .fcr_we_o (fcr_we_o),
    .iir_rd_o (iir_rd),
    .lsr_rd_o (lsr_rd),
    .msr_rd_o (msr_rd),
    .tx_arm_o (tx_arm)
  );

  uart_line_status u_lsr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       ({brk_i, frm_err_i, par_err_i, ovr_err_i}),
    .clr_i       (lsr_rd),
    .rx_avail_i  (rx_avail_i),
    .thr_empty_i (thr_empty_i),
    .tx_empty_i  (tx_empty_i),
    .lsr_o       (lsr),
    .err_any_o   (err_any)
  );

  uart_modem_status u_msr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    ({dcd_i, ri_i, dsr_i, cts_i}),
    .clr_i     (msr_rd),
    .msr_o     (msr),
    .chg_any_o (chg_any)
  );

  uart_irq_encoder u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ier_i       (ier),
    .ls_any_i    (err_any),
    .rx_avail_i  (rx_avail_i),
    .thr_empty_i (thr_empty_i),
    .ms_any_i    (chg_any),
    .tx_arm_i    (tx_arm),
    .tx_we_i     (tx_we_o),
    .iir_rd_i    (iir_rd),
    .iir_o       (iir),
    .irq_o       (irq_o)
  );

  assign divisor_o = {dlm, dll};

  always_comb begin
    case (addr_i)
      OFS_DATA: rdata_o = lcr_o[DLAB_BIT] ? dll : rx_data_i;
      OFS_IER:  rdata_o = lcr_o[DLAB_BIT] ? dlm : {{EN_PAD{1'b0}}, ier};
      OFS_IIR:  rdata_o = iir;
      OFS_LCR:  rdata_o = lcr_o;
      OFS_MCR:  rdata_o = mcr_o;
      OFS_LSR:  rdata_o = lsr;
      OFS_MSR:  rdata_o = msr;
      default:  rdata_o = '0;
    endcase
  end

  assert_irq_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd && ier == 4'b0100 && {brk_i, frm_err_i, par_err_i, ovr_err_i} == 4'b0) |=> !irq_o);
endmodule

// File: tb/uart_irq_status_core_tb_top.sv
`timescale 1ns/1ps
module uart_irq_status_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 0, rd = 0, wr = 0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata, rx_data = '0, lcr, mcr;
  logic        rx_avail = 0, ovr = 0, par = 0, frm = 0, brk = 0;
  logic        thr_empty = 0, tx_empty = 0, cts = 0, dsr = 0, ri = 0, dcd = 0;
  logic        tx_we, rx_rd, fcr_we, irq;
  logic [15:0] divisor;

  int unsigned vectors = 0, miscompares = 0;
  logic        s_tx_we, s_rx_rd, s_fcr_we;

  always #2.5 clk = ~clk;

  uart_irq_status_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data),
    .rx_avail_i(rx_avail), .ovr_err_i(ovr), .par_err_i(par), .frm_err_i(frm),
    .brk_i(brk), .thr_empty_i(thr_empty), .tx_empty_i(tx_empty),
    .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .tx_we_o(tx_we), .rx_rd_o(rx_rd), .fcr_we_o(fcr_we),
    .lcr_o(lcr), .mcr_o(mcr), .divisor_o(divisor), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = a; wdata = d;
    #1;
    s_tx_we = tx_we; s_fcr_we = fcr_we;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    #1;
    d = rdata; s_rx_rd = rx_rd;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic idle_sample();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    idle_sample();
    chk("R1 irq", {15'b0, irq}, 16'h0);
    bus_rd(3'd2, d); chk("R1 iir", {8'h0, d}, 16'h0001);
    bus_rd(3'd3, d); chk("R1 lcr", {8'h0, d}, 16'h0000);
    bus_rd(3'd4, d); chk("R1 mcr", {8'h0, d}, 16'h0000);
    bus_rd(3'd5, d); chk("R1 lsr", {8'h0, d}, 16'h0000);
    bus_rd(3'd6, d); chk("R1 msr", {8'h0, d}, 16'h00F0);
    bus_rd(3'd7, d); chk("R2 offset7", {8'h0, d}, 16'h0000);

    // R2 divisor banking
    bus_wr(3'd3, 8'h83);
    bus_wr(3'd0, 8'h34);
    chk("R10 no tx strobe under latch access", {15'b0, s_tx_we}, 16'h0);
    bus_wr(3'd1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    bus_rd(3'd0, d); chk("R2 dll read", {8'h0, d}, 16'h0034);
    chk("R10 no rx pop under latch access", {15'b0, s_rx_rd}, 16'h0);
    bus_rd(3'd1, d); chk("R2 dlm read", {8'h0, d}, 16'h0012);
    bus_wr(3'd3, 8'h03);
    chk("R2 lcr out", {8'h0, lcr}, 16'h0003);
    bus_rd(3'd1, d); chk("R2 ier untouched", {8'h0, d}, 16'h0000);
    bus_wr(3'd1, 8'hF0);
    bus_rd(3'd1, d); chk("R3 ier mask", {8'h0, d}, 16'h0000);
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd4, 8'h1B);
    bus_rd(3'd4, d); chk("R2 mcr", {8'h0, d}, 16'h001B);
    chk("R2 mcr out", {8'h0, mcr}, 16'h001B);

    // R10 data strobes
    rx_data = 8'hA5;
    bus_rd(3'd0, d);
    chk("R10 rx data", {8'h0, d}, 16'h00A5);
    chk("R10 rx pop", {15'b0, s_rx_rd}, 16'h1);
    bus_wr(3'd0, 8'h11);
    chk("R10 tx strobe", {15'b0, s_tx_we}, 16'h1);
    bus_wr(3'd2, 8'hC7);
    chk("R10 fcr strobe", {15'b0, s_fcr_we}, 16'h1);
    chk("R10 no tx on fcr", {15'b0, s_tx_we}, 16'h0);

    // R5 same-cycle error during line status read
    @(negedge clk); ovr = 1; @(negedge clk); ovr = 0;
    @(negedge clk); cs = 1; rd = 1; addr = 3'd5; frm = 1;
    #1; d = rdata;
    @(negedge clk); cs = 0; rd = 0; frm = 0;
    chk("R5 read shows overrun", {8'h0, d}, 16'h0002);
    bus_rd(3'd5, d); chk("R5 new framing kept", {8'h0, d}, 16'h0008);
    bus_rd(3'd5, d); chk("R5 cleared", {8'h0, d}, 16'h0000);
    // R4 level bits
    tx_empty = 1; thr_empty = 1; rx_avail = 1;
    @(negedge clk); brk = 1; @(negedge clk); brk = 0;
    bus_rd(3'd5, d); chk("R4 levels and break", {8'h0, d}, 16'h0071);
    tx_empty = 0; thr_empty = 0; rx_avail = 0;
    bus_wr(3'd0, 8'h00);

    // R7 same-cycle modem change during status read
    @(negedge clk); dsr = 1;
    @(negedge clk); cs = 1; rd = 1; addr = 3'd6; ri = 1;
    #1; d = rdata;
    @(negedge clk); cs = 0; rd = 0;
    chk("R6 dsr change", {8'h0, d}, 16'h00D2);
    bus_rd(3'd6, d); chk("R7 ri change kept", {8'h0, d}, 16'h0094);
    bus_rd(3'd6, d); chk("R7 cleared", {8'h0, d}, 16'h0090);
    @(negedge clk); dsr = 0; ri = 0;
    bus_rd(3'd6, d); chk("R6 falling changes", {8'h0, d}, 16'h00F6);

    // R9 arming by enable write while holding register empty
    @(negedge clk); thr_empty = 1;
    bus_wr(3'd0, 8'h00);
    bus_rd(3'd2, d); chk("R9 tx write cleared", {8'h0, d}, 16'h0001);
    bus_wr(3'd1, 8'h02);
    bus_rd(3'd2, d); chk("R9 armed by enable", {8'h0, d}, 16'h0002);
    bus_rd(3'd2, d); chk("R9 cleared by id read", {8'h0, d}, 16'h0001);
    idle_sample(); chk("R3 irq low after id read", {15'b0, irq}, 16'h0);
    @(negedge clk); thr_empty = 0;
    bus_wr(3'd1, 8'h00);

    // R3 drop after line status read
    bus_wr(3'd1, 8'h04);
    @(negedge clk); brk = 1; @(negedge clk); brk = 0;
    idle_sample(); chk("R3 irq on break", {15'b0, irq}, 16'h1);
    bus_rd(3'd5, d);
    idle_sample(); chk("R3 irq drops", {15'b0, irq}, 16'h0);

    // Sweep: all enable masks x all source combinations (R8 priority)
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0] s, s_after;
        logic [7:0] exp_id;
        bus_wr(3'd1, m[7:0]);
        if (p[2]) begin @(negedge clk); par = 1; @(negedge clk); par = 0; end
        @(negedge clk);
        rx_avail = p[0];
        thr_empty = p[1];
        if (p[3]) cts = ~cts;
        s = p[3:0] & m[3:0];
        if (s[2])      exp_id = 8'h06;
        else if (s[0]) exp_id = 8'h04;
        else if (s[1]) exp_id = 8'h02;
        else if (s[3]) exp_id = 8'h00;
        else           exp_id = 8'h01;
        idle_sample();
        chk($sformatf("R3 irq m=%0d p=%0d", m, p), {15'b0, irq}, {15'b0, |s});
        bus_rd(3'd2, d);
        chk($sformatf("R8 id m=%0d p=%0d", m, p), {8'h0, d}, {8'h0, exp_id});
        s_after = s & ~((exp_id == 8'h02) ? 4'b0010 : 4'b0000);
        idle_sample();
        chk($sformatf("R9 irq after id m=%0d p=%0d", m, p), {15'b0, irq}, {15'b0, |s_after});
        bus_rd(3'd5, d);
        chk($sformatf("R4 lsr p=%0d", p), {8'h0, d},
            {8'h0, 2'b00, p[1], 2'b00, p[2], 1'b0, p[0]});
        bus_rd(3'd6, d);
        chk($sformatf("R6 msr p=%0d", p), {8'h0, d},
            {8'h0, 3'b111, ~cts, 3'b000, p[3]});
        @(negedge clk); rx_avail = 0; thr_empty = 0;
        bus_wr(3'd0, 8'h00);
        bus_rd(3'd2, d);
        chk($sformatf("R8 idle m=%0d p=%0d", m, p), {8'h0, d}, 16'h0001);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule